// File: doc/BRIEF.md
# Extended-Precision Float to Signed Integer Converter

This block turns one extended-precision floating-point operand (sign bit, 15-bit biased exponent, 64-bit significand with an explicit integer bit) into a signed integer of 16, 32 or 64 bits. The destination width is chosen per operation. Fractional values are rounded according to a 2-bit rounding field. A separate chop request forces rounding toward zero, whatever that field holds.

Each operation is offered on a valid/ready input. Ready is always high. The result appears a fixed two cycles later. Alongside the integer, the block reports an invalid flag, a precision (inexact) flag and a round-direction bit. It also produces a store-enable, which tells the surrounding datapath whether the result may be written. When an operand cannot be represented, the result is the integer indefinite value. That value is stored only if the invalid exception is masked.

Top module: `fp_to_int_conv`

## Requirements
- R1: `in_ready` is high at all times after reset. `out_valid` rises exactly two clock cycles after an accepted `in_valid` and is low in the cycle between. After reset, `out_valid` is low.
- R2: `in_size` selects the destination: 00 gives 16 bits, 01 gives 32 bits, and 10 or 11 give 64 bits. `out_int` carries the result sign-extended from the selected width to 64 bits.
- R3: `in_rc` = 00 rounds to the nearest integer. An exact tie goes to the even integer.
- R4: `in_rc` = 01 rounds toward minus infinity, `in_rc` = 10 rounds toward plus infinity, and `in_rc` = 11 truncates toward zero.
- R5: When `in_chop` is 1, the value is truncated toward zero whatever `in_rc` holds.
- R6: A nonzero magnitude below 1 gives 0, +1 or -1 as the rounding mode dictates. Under truncation, any value strictly between -1 and +1 gives 0.
- R7: `out_invalid` is 1 in each of these cases: exponent all ones (infinity or NaN); a nonzero exponent with significand bit 63 clear (unsupported encoding); a rounded signed result outside the destination range.
- R8: The range check applies to the signed rounded value. -2^(N-1) converts without invalid, and +2^(N-1) is invalid.
- R9: On invalid, `out_int` is the most negative value of the destination width, sign-extended to 64 bits (16-bit: FFFF_FFFF_FFFF_8000). `out_store_en` equals `in_inv_mask` on invalid and is 1 otherwise.
- R10: `out_precision` is 1 exactly when a valid result differs from the source value. It is 0 on invalid.
- R11: `out_c1` is 1 only when an inexact result was rounded to a larger magnitude. It is 0 for exact results, for invalid results, and whenever `in_chop` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Always 1: one operation per cycle |
| in_sign | input | 1 | Operand sign |
| in_exp | input | 15 | Operand biased exponent (bias 16383) |
| in_sig | input | 64 | Operand significand, bit 63 is the integer bit |
| in_size | input | 2 | Destination width select |
| in_rc | input | 2 | Rounding control |
| in_chop | input | 1 | Force truncation toward zero |
| in_inv_mask | input | 1 | Invalid exception masked |
| out_valid | output | 1 | Result valid |
| out_int | output | 64 | Signed result, sign-extended |
| out_invalid | output | 1 | Invalid-operation flag |
| out_precision | output | 1 | Inexact flag |
| out_c1 | output | 1 | Inexact result rounded up in magnitude |
| out_store_en | output | 1 | Result may be written |

## Verification
The bench builds the block with its default parameters: a 15-bit exponent and a 64-bit datapath. At these values all three destination widths are reachable, and so is the extreme 64-bit boundary, where 2^63 is invalid and -2^63 converts. Random operands are built from a chosen integer part and one of several fraction patterns (quarter, half, three quarters, just above half). Integer bit lengths are drawn up to one past the destination width, so overflow and the edges of each range come up often. Directed cases cover rounding ties, magnitudes below one, specials and masked versus unmasked invalid.

// File: rtl/fti_pkg.sv
// Shared encodings for the float-to-integer converter.
// Assumes the rounding field and size select are both 2 bits wide.
package fti_pkg;

    typedef enum logic [1:0] {
        RC_NEAR = 2'b00,
        RC_DOWN = 2'b01,
        RC_UP   = 2'b10,
        RC_CHOP = 2'b11
    } rc_e;

    typedef enum logic [1:0] {
        SZ_Q  = 2'b00,
        SZ_H  = 2'b01,
        SZ_F  = 2'b10,
        SZ_F2 = 2'b11
    } size_e;

    localparam int NUM_SIZES = 3;

    // Map a size select onto an index into the per-width tables.
    function automatic logic [1:0] size_index(input logic [1:0] sz);
        return (sz == SZ_F2) ? 2'd2 : sz;
    endfunction

endpackage

// File: rtl/fti_align.sv
// Operand classifier and aligner.
// Splits the significand into an integer part plus guard and sticky bits,
// and flags specials and magnitudes far beyond the widest destination.
// Assumes the significand is DW bits wide with an explicit integer bit.
module fti_align #(
    parameter int EXP_W = 15,
    parameter int DW    = 64
) (
    input  logic [EXP_W-1:0] exp_i,
    input  logic [DW-1:0]    sig_i,
    output logic             special_o,
    output logic             big_o,
    output logic [DW-1:0]    ipart_o,
    output logic             guard_o,
    output logic             sticky_o
);

    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int SH_W = $clog2(DW) + 1;
    localparam logic [EXP_W-1:0] EXP_MAX = '1;

    logic signed [EXP_W+1:0] e_unb;
    logic [SH_W-1:0]         rsh;
    logic [SH_W-1:0]         lsh;
    logic [DW-1:0]           frac;

    // Unbiased exponent and the shift amounts derived from it.
    always_comb begin
        e_unb = $signed({2'b00, exp_i}) - $signed((EXP_W+2)'(BIAS));
        rsh   = SH_W'(DW - 1) - e_unb[SH_W-1:0];
        lsh   = e_unb[SH_W-1:0] + SH_W'(1);
        frac  = sig_i << lsh;
    end

    // Classify the operand and pick integer, guard and sticky values.
    always_comb begin
        special_o = 1'b0;
        big_o     = 1'b0;
        ipart_o   = '0;
        guard_o   = 1'b0;
        sticky_o  = 1'b0;
        if (exp_i == EXP_MAX) begin
            special_o = 1'b1;
        end else if (exp_i == '0) begin
            sticky_o = |sig_i;
        end else if (!sig_i[DW-1]) begin
            special_o = 1'b1;
        end else if (e_unb >= $signed((EXP_W+2)'(DW))) begin
            big_o = 1'b1;
        end else if (e_unb >= 0) begin
            ipart_o  = sig_i >> rsh;
            guard_o  = frac[DW-1];
            sticky_o = |frac[DW-2:0];
        end else if (e_unb == -1) begin
            guard_o  = sig_i[DW-1];
            sticky_o = |sig_i[DW-2:0];
        end else begin
            sticky_o = 1'b1;
        end
    end

endmodule

// File: rtl/fti_round.sv
// Rounding stage: applies the effective rounding mode to the magnitude.
// Assumes chop has already been folded into rc_i as truncate.
module fti_round #(
    parameter int DW = 64
) (
    input  logic          sign_i,
    input  logic [DW-1:0] ipart_i,
    input  logic          guard_i,
    input  logic          sticky_i,
    input  logic [1:0]    rc_i,
    output logic [DW:0]   mag_o,
    output logic          inexact_o,
    output logic          up_o
);
    import fti_pkg::*;

    // Decide whether the magnitude is incremented.
    always_comb begin
        inexact_o = guard_i | sticky_i;
        case (rc_e'(rc_i))
            RC_NEAR: up_o = guard_i & (sticky_i | ipart_i[0]);
            RC_DOWN: up_o = sign_i & inexact_o;
            RC_UP:   up_o = !sign_i & inexact_o;
            default: up_o = 1'b0;
        endcase
        mag_o = {1'b0, ipart_i} + (DW+1)'(up_o);
    end

endmodule

// File: rtl/fti_range.sv
// Range checker and indefinite-value source for every destination width.
// Limits apply to the signed value: -2^(W-1) fits, +2^(W-1) does not.
// Assumes DW is divisible by 4; the widths are DW/4, DW/2 and DW.
module fti_range #(
    parameter int DW = 64
) (
    input  logic          sign_i,
    input  logic [DW:0]   mag_i,
    input  logic [1:0]    size_i,
    output logic          fits_o,
    output logic [DW-1:0] indef_o
);
    import fti_pkg::*;

    logic          fit_w [NUM_SIZES];
    logic [DW-1:0] indef_w [NUM_SIZES];

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_width
        localparam int          W   = (DW / 4) << g;
        localparam logic [DW:0] LIM = (DW+1)'(1) << (W - 1);
        assign fit_w[g]   = sign_i ? (mag_i <= LIM) : (mag_i < LIM);
        assign indef_w[g] = {DW{1'b1}} << (W - 1);
    end

    // Select the verdict and the indefinite value for the chosen width.
    always_comb begin
        fits_o  = fit_w[size_index(size_i)];
        indef_o = indef_w[size_index(size_i)];
    end

endmodule

// File: rtl/fp_to_int_conv.sv
// Extended-precision float to signed integer converter, top level.
// Stage 1 registers the classified and aligned operand.
// Stage 2 rounds, checks the range, formats the result and registers it.
// Assumes a fixed two-cycle latency and accepts one operation per cycle.
module fp_to_int_conv #(
    parameter int EXP_W = 15,
    parameter int DW    = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_sign,
    input  logic [EXP_W-1:0] in_exp,
    input  logic [DW-1:0]    in_sig,
    input  logic [1:0]       in_size,
    input  logic [1:0]       in_rc,
    input  logic             in_chop,
    input  logic             in_inv_mask,
    output logic             out_valid,
    output logic [DW-1:0]    out_int,
    output logic             out_invalid,
    output logic             out_precision,
    output logic             out_c1,
    output logic             out_store_en
);
    import fti_pkg::*;

    logic          a_special, a_big, a_guard, a_sticky;
    logic [DW-1:0] a_ipart;

    logic          s1_valid, s1_sign, s1_special, s1_big;
    logic          s1_guard, s1_sticky, s1_mask;
    logic [DW-1:0] s1_ipart;
    logic [1:0]    s1_size, s1_rc;

    logic [DW:0]   r_mag;
    logic          r_inexact, r_up;
    logic          g_fits;
    logic [DW-1:0] g_indef;
    logic          c_invalid;
    logic [DW-1:0] c_result;

    assign in_ready = 1'b1;

    fti_align #(.EXP_W(EXP_W), .DW(DW)) align_i (
        .exp_i     (in_exp),
        .sig_i     (in_sig),
        .special_o (a_special),
        .big_o     (a_big),
        .ipart_o   (a_ipart),
        .guard_o   (a_guard),
        .sticky_o  (a_sticky)
    );

    // Stage 1 register: aligned operand and the controls that go with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid   <= 1'b0;
            s1_sign    <= 1'b0;
            s1_special <= 1'b0;
            s1_big     <= 1'b0;
            s1_ipart   <= '0;
            s1_guard   <= 1'b0;
            s1_sticky  <= 1'b0;
            s1_size    <= SZ_Q;
            s1_rc      <= RC_NEAR;
            s1_mask    <= 1'b0;
        end else begin
            s1_valid   <= in_valid;
            s1_sign    <= in_sign;
            s1_special <= a_special;
            s1_big     <= a_big;
            s1_ipart   <= a_ipart;
            s1_guard   <= a_guard;
            s1_sticky  <= a_sticky;
            s1_size    <= in_size;
            s1_rc      <= in_chop ? RC_CHOP : in_rc;
            s1_mask    <= in_inv_mask;
        end
    end

    fti_round #(.DW(DW)) round_i (
        .sign_i    (s1_sign),
        .ipart_i   (s1_ipart),
        .guard_i   (s1_guard),
        .sticky_i  (s1_sticky),
        .rc_i      (s1_rc),
        .mag_o     (r_mag),
        .inexact_o (r_inexact),
        .up_o      (r_up)
    );

    fti_range #(.DW(DW)) range_i (
        .sign_i  (s1_sign),
        .mag_i   (r_mag),
        .size_i  (s1_size),
        .fits_o  (g_fits),
        .indef_o (g_indef)
    );

    // Combine the verdicts and form the signed result.
    always_comb begin
        c_invalid = s1_special | s1_big | !g_fits;
        if (c_invalid)
            c_result = g_indef;
        else if (s1_sign)
            c_result = ~r_mag[DW-1:0] + DW'(1);
        else
            c_result = r_mag[DW-1:0];
    end

    // Stage 2 register: result, flags and store permission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_int       <= '0;
            out_invalid   <= 1'b0;
            out_precision <= 1'b0;
            out_c1        <= 1'b0;
            out_store_en  <= 1'b0;
        end else begin
            out_valid     <= s1_valid;
            out_int       <= c_result;
            out_invalid   <= c_invalid;
            out_precision <= r_inexact & !c_invalid;
            out_c1        <= r_up & !c_invalid;
            out_store_en  <= !c_invalid | s1_mask;
        end
    end

endmodule

// File: rtl/fp_to_int_conv_chk.sv
// Property checker for the converter, attached through bind.
// Keeps its own two-stage copy of the valid and control inputs.
module fp_to_int_conv_chk #(
    parameter int EXP_W = 15,
    parameter int DW    = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [1:0]       in_size,
    input logic             in_chop,
    input logic             in_inv_mask,
    input logic             out_valid,
    input logic [DW-1:0]    out_int,
    input logic             out_invalid,
    input logic             out_precision,
    input logic             out_c1,
    input logic             out_store_en
);

    logic       v1, v2, ch1, ch2, m1, m2;
    logic [1:0] sz1, sz2;
    logic [DW-1:0] indef_exp;

    // Delay line for valid and the controls, aligned with the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0; v2 <= 1'b0; ch1 <= 1'b0; ch2 <= 1'b0;
            m1 <= 1'b0; m2 <= 1'b0; sz1 <= '0; sz2 <= '0;
        end else begin
            v1 <= in_valid;  v2 <= v1;
            ch1 <= in_chop;  ch2 <= ch1;
            m1 <= in_inv_mask; m2 <= m1;
            sz1 <= in_size;  sz2 <= sz1;
        end
    end

    // Expected indefinite value for the delayed size.
    always_comb begin
        case (sz2)
            2'b00:   indef_exp = {DW{1'b1}} << (DW/4 - 1);
            2'b01:   indef_exp = {DW{1'b1}} << (DW/2 - 1);
            default: indef_exp = {DW{1'b1}} << (DW - 1);
        endcase
    end

    // R1
    ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) in_ready);
    // R1
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n) out_valid == v2);
    // R2
    sext_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_invalid && sz2 == 2'b00) |->
        ((&out_int[DW-1:DW/4-1]) || !(|out_int[DW-1:DW/4-1])));
    // R2
    sext_h_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_invalid && sz2 == 2'b01) |->
        ((&out_int[DW-1:DW/2-1]) || !(|out_int[DW-1:DW/2-1])));
    // R9
    indef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> out_int == indef_exp);
    // R9
    store_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_store_en == (!out_invalid || m2));
    // R10
    prec_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> !out_precision);
    // R11
    c1_prec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_c1) |-> out_precision);
    // R11
    chop_c1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ch2) |-> !out_c1);

endmodule

bind fp_to_int_conv fp_to_int_conv_chk #(.EXP_W(EXP_W), .DW(DW)) chk_i (.*);

// File: tb/fp_to_int_conv_tb_top.sv
`timescale 1ns/1ps
module fp_to_int_conv_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_sign = 1'b0;
    logic [14:0] in_exp = '0;
    logic [63:0] in_sig = '0;
    logic [1:0]  in_size = '0;
    logic [1:0]  in_rc = '0;
    logic        in_chop = 1'b0;
    logic        in_inv_mask = 1'b0;
    logic        out_valid;
    logic [63:0] out_int;
    logic        out_invalid, out_precision, out_c1, out_store_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fp_to_int_conv dut_i (.*);

    task automatic check(input bit ok, input string tag, input logic [67:0] act, input logic [67:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Fraction pattern for a category: 0, 1/4, 1/2, 3/4, 9/16.
    function automatic logic [63:0] frac_pat(input int fc);
        case (fc)
            1: return 64'h4000_0000_0000_0000;
            2: return 64'h8000_0000_0000_0000;
            3: return 64'hC000_0000_0000_0000;
            4: return 64'h9000_0000_0000_0000;
            default: return 64'h0;
        endcase
    endfunction

    // Build an operand equal to m + fraction.
    task automatic build(input logic [63:0] m, input int fc, output logic [14:0] ex, output logic [63:0] mt);
        logic [63:0] fp;
        int l, lz;
        fp = frac_pat(fc);
        l = 0;
        for (int i = 0; i < 64; i++) if (m[i]) l = i + 1;
        if (l != 0) begin
            mt = (m << (64 - l)) | (fp >> l);
            ex = 15'(16383 + l - 1);
        end else if (fp != 0) begin
            lz = 0;
            while (!fp[63 - lz]) lz++;
            mt = fp << lz;
            ex = 15'(16383 - 1 - lz);
        end else begin
            mt = '0;
            ex = '0;
        end
    endtask

    // Expected {result, invalid, precision, c1, store} from the requirements.
    function automatic logic [67:0] model(input logic s, input logic [63:0] m, input int fc,
                                          input logic [1:0] rc, input logic chop,
                                          input logic [1:0] sz, input logic mask);
        int w;
        logic [1:0] mode;
        logic inx, up;
        logic [64:0] r, lim;
        logic bad;
        logic [63:0] res;
        w = (sz == 2'b00) ? 16 : (sz == 2'b01) ? 32 : 64;
        mode = chop ? 2'b11 : rc;
        inx = (fc != 0);
        case (mode)
            2'b00: up = (fc == 3 || fc == 4) || (fc == 2 && m[0]);
            2'b01: up = inx && s;
            2'b10: up = inx && !s;
            default: up = 1'b0;
        endcase
        r = {1'b0, m} + 65'(up);
        lim = 65'd1 << (w - 1);
        bad = s ? (r > lim) : (r >= lim);
        if (bad) begin
            res = {64{1'b1}} << (w - 1);
            return {res, 1'b1, 1'b0, 1'b0, mask};
        end
        res = s ? (64'd0 - r[63:0]) : r[63:0];
        return {res, 1'b0, inx, up, 1'b1};
    endfunction

    // Issue one raw operand and compare two cycles later.
    task automatic run_raw(input logic s, input logic [14:0] ex, input logic [63:0] mt,
                           input logic [1:0] sz, input logic [1:0] rc, input logic chop,
                           input logic mask, input logic [67:0] exp, input string tag);
        logic [67:0] act;
        @(negedge clk);
        in_valid = 1'b1; in_sign = s; in_exp = ex; in_sig = mt;
        in_size = sz; in_rc = rc; in_chop = chop; in_inv_mask = mask;
        @(negedge clk);
        in_valid = 1'b0;
        // R1: nothing valid in the intermediate cycle
        if (out_valid) begin
            n_chk++; n_fail++;
            $display("FAIL R1 actual=out_valid 1 expected=0 (mid cycle)");
        end
        @(negedge clk);
        act = {out_int, out_invalid, out_precision, out_c1, out_store_en};
        check(out_valid, "R1", {67'd0, out_valid}, 68'd1);
        check(act == exp, tag, act, exp);
    endtask

    task automatic run(input logic s, input logic [63:0] m, input int fc,
                       input logic [1:0] sz, input logic [1:0] rc, input logic chop,
                       input logic mask, input string tag);
        logic [14:0] ex;
        logic [63:0] mt;
        build(m, fc, ex, mt);
        run_raw(s, ex, mt, sz, rc, chop, mask, model(s, m, fc, rc, chop, sz, mask), tag);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!out_valid, "R1", {67'd0, out_valid}, 68'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready, "R1", {67'd0, in_ready}, 68'd1);

        // R3: nearest, ties to even
        run(0, 64'd1234, 3, 2'b00, 2'b00, 0, 1, "R3");
        run(0, 64'd2, 2, 2'b00, 2'b00, 0, 1, "R3");
        run(0, 64'd3, 2, 2'b01, 2'b00, 0, 1, "R3");
        run(1, 64'd7, 4, 2'b10, 2'b00, 0, 1, "R3");
        // R4: directed modes
        run(1, 64'd2, 1, 2'b00, 2'b01, 0, 1, "R4");
        run(0, 64'd2, 1, 2'b00, 2'b10, 0, 1, "R4");
        run(1, 64'd2, 3, 2'b01, 2'b10, 0, 1, "R4");
        run(1, 64'd2, 3, 2'b11, 2'b11, 0, 1, "R4");
        // R5: chop overrides the rounding field
        run(0, 64'd2, 3, 2'b00, 2'b00, 1, 1, "R5");
        run(1, 64'd9, 4, 2'b01, 2'b01, 1, 1, "R5");
        // R6: magnitudes below one
        run(0, 64'd0, 1, 2'b00, 2'b10, 0, 1, "R6");
        run(1, 64'd0, 1, 2'b00, 2'b01, 0, 1, "R6");
        run(0, 64'd0, 2, 2'b00, 2'b00, 0, 1, "R6");
        run(1, 64'd0, 3, 2'b00, 2'b00, 0, 1, "R6");
        run(1, 64'd0, 3, 2'b01, 2'b01, 1, 1, "R6");
        // R10: exact values and zero
        run(0, 64'd100, 0, 2'b00, 2'b00, 0, 0, "R10");
        run(0, 64'd0, 0, 2'b01, 2'b10, 0, 0, "R10");
        // R8: boundaries on the signed value
        run(0, 64'd32767, 0, 2'b00, 2'b00, 0, 1, "R8");
        run(0, 64'd32768, 0, 2'b00, 2'b00, 0, 1, "R8");
        run(1, 64'd32768, 0, 2'b00, 2'b00, 0, 0, "R8");
        run(1, 64'd32768, 2, 2'b00, 2'b00, 0, 0, "R8");
        run(1, 64'd32768, 3, 2'b00, 2'b00, 0, 1, "R8");
        run(0, 64'd2147483647, 2, 2'b01, 2'b00, 0, 1, "R8");
        run(1, 64'h8000_0000_0000_0000, 0, 2'b10, 2'b00, 0, 0, "R8");
        run(0, 64'h8000_0000_0000_0000, 0, 2'b11, 2'b00, 0, 0, "R8");
        // R7/R9: specials, masked and unmasked
        run_raw(0, 15'h7FFF, 64'h8000_0000_0000_0000, 2'b00, 2'b00, 0, 1,
                {64'hFFFF_FFFF_FFFF_8000, 1'b1, 1'b0, 1'b0, 1'b1}, "R7/R9 inf masked");
        run_raw(1, 15'h7FFF, 64'hC000_0000_0000_0000, 2'b01, 2'b00, 0, 0,
                {64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0, 1'b0, 1'b0}, "R7/R9 nan unmasked");
        run_raw(0, 15'd16390, 64'h4000_0000_0000_0000, 2'b10, 2'b00, 0, 1,
                {64'h8000_0000_0000_0000, 1'b1, 1'b0, 1'b0, 1'b1}, "R7 unsupported");
        run_raw(0, 15'd16453, 64'h8000_0000_0000_0000, 2'b10, 2'b00, 0, 0,
                {64'h8000_0000_0000_0000, 1'b1, 1'b0, 1'b0, 1'b0}, "R7 huge");

        // R2/R3/R4/R10/R11: random operands around every width
        for (int k = 0; k < 500; k++) begin
            logic [1:0] sz, rc;
            logic s, chop, mask;
            logic [63:0] m;
            int w, lr, fc;
            sz = 2'($urandom_range(0, 3));
            rc = 2'($urandom_range(0, 3));
            s = 1'($urandom_range(0, 1));
            chop = ($urandom_range(0, 3) == 0);
            mask = 1'($urandom_range(0, 1));
            fc = $urandom_range(0, 4);
            w = (sz == 2'b00) ? 16 : (sz == 2'b01) ? 32 : 64;
            lr = $urandom_range(0, w + 1);
            if (lr > 64) lr = 64;
            if (lr > 60) fc = 0;
            if (lr == 0) m = '0;
            else begin
                m = {$urandom, $urandom};
                if (lr < 64) m = m & ((64'd1 << lr) - 64'd1);
                m = m | (64'd1 << (lr - 1));
            end
            run(s, m, fc, sz, rc, chop, mask, "R2/R4/R10/R11 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule